// File: doc/BRIEF.md
# Sequential Signed/Unsigned 32-by-16 Divider

This block divides a 32-bit dividend by a 16-bit divisor over many clock cycles. It handles unsigned and two's-complement signed operands. A single `start_i` pulse latches the operands and the mode. The block turns both operands into magnitudes, runs a restoring shift-and-subtract loop that yields one quotient bit per step, and then applies the signs in a fix-up state. It checks the result for overflow and reports it on a one-cycle `done_o` pulse.

A successful result packs the 16-bit remainder into bits 31:16 and the 16-bit quotient into bits 15:0. It comes with a one-cycle `wr_en_o` that tells the destination register to take it. A quotient that does not fit in 16 bits sets the overflow flag and suppresses the write. A zero divisor produces no result at all; it raises a trap pulse that carries a fixed vector number. When an overflow can already be seen from the magnitudes, the loop is skipped and the block finishes right away.

The controller has three states. `S_IDLE` waits for `start_i`. `S_RUN` executes the quotient loop. `S_FIX` signs the quotient and remainder, checks overflow and retires. The transitions are:
- START_LOOP: `S_IDLE` to `S_RUN`, on a start with a usable divisor and no early overflow.
- FINISH_FAST: `S_IDLE` to `S_IDLE`, on a start that traps or overflows early.
- LOOP_DONE: `S_RUN` to `S_FIX`, after the last loop step.
- RETIRE: `S_FIX` to `S_IDLE`, at the `done_o` pulse.

Top module: `seq_div32x16`

## Requirements
- R1: When bits 15:0 of `divisor_i` are zero at start, the following happen after the edge that samples start:
  - `done_o` and `trap_o` pulse high together and `trap_vec_o` reads 0x14 (it reads 0 whenever `trap_o` is low).
  - `wr_en_o` stays low.
  - `result_o` and `flags_o` keep their previous values.
- R2: Bits 31:16 of `divisor_i` never affect the outcome. In signed mode, bits 15:0 are taken as a signed 16-bit value.
- R3: Unsigned success: `result_o` = {dividend mod divisor, dividend / divisor}, the quotient in bits 15:0, and `wr_en_o` pulses with `done_o`. Under default parameters, `done_o` is seen after the 34th rising edge, counting the edge that samples start as the first.
- R4: In signed mode, the quotient is truncated toward zero and is negative exactly when one operand is negative. The remainder carries the sign of the dividend.
- R5: On a written result, `flags_o` = {N, Z, V, C} in bits 3:0. N is bit 15 of the quotient, Z is set when the 16-bit quotient is zero, and V and C are 0.
- R6: On overflow, V (bit 1) is set, C (bit 0) is cleared, N and Z keep their previous values, `wr_en_o` stays low and `result_o` holds.
  - Unsigned overflow means the quotient is at least 2^16.
  - Signed overflow means the quotient lies outside -32768..32767.
- R7: When (magnitude of dividend >> 16) >= magnitude of divisor, the overflow is reported on `done_o` after the edge that samples start, and `busy_o` never rises.
- R8: A signed quotient whose magnitude fits in 16 bits but whose signed value does not (for example +32768) is flagged as overflow after the full loop, with the R3 latency.
- R9: `busy_o` is high from the edge after a looping start until `done_o` rises. It is low while `done_o` is high, and `done_o` lasts exactly one cycle.
- R10: `start_i` and the operand inputs are ignored while `busy_o` is high.
- R11: During and just after reset, `busy_o`, `done_o`, `wr_en_o` and `trap_o` are low, and `result_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division (sampled only in idle) |
| signed_i | input | 1 | 1 = two's-complement operands |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor; only bits 15:0 are used |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Destination write enable, with done on success |
| result_o | output | 32 | {remainder, quotient} of the last written result |
| flags_o | output | 4 | {N, Z, V, C} |
| trap_o | output | 1 | Divide-by-zero trap pulse |
| trap_vec_o | output | 8 | Trap vector number while trap_o is high |

## Verification
A corrupted partial remainder or quotient bit in `S_RUN` stays hidden until `S_FIX`. It then appears as a wrong `result_o`, a wrong N/Z, or a false overflow in the `done_o` cycle, 34 edges after start. A wrong step count or a stuck state shows up sooner, as `done_o` arriving on the wrong cycle or `busy_o` failing to fall. A wrongly latched sign shows up only in signed runs with mixed operand signs, so the directed cases cover all four sign pairings and the +32768/-32768 boundary.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIX  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } div_ccr_t;

endpackage

// File: rtl/div_operand_prep.sv
`timescale 1ns/1ps
// Turns the raw operands into magnitudes, records their signs and
// flags the two cases that finish without running the loop.
module div_operand_prep #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             sgn_i,
    input  logic [DVD_W-1:0] dvd_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic [DVD_W-1:0] dvd_mag_o,
    output logic [DVS_W-1:0] dvs_mag_o,
    output logic             dvd_neg_o,
    output logic             dvs_neg_o,
    output logic             dvs_zero_o,
    output logic             early_ovf_o
);
    localparam int HI_W = DVD_W - DVS_W;

    logic [HI_W-1:0] mag_hi;

    always_comb begin
        dvd_neg_o  = sgn_i & dvd_i[DVD_W-1];
        dvs_neg_o  = sgn_i & dvs_i[DVS_W-1];
        dvd_mag_o  = dvd_neg_o ? -dvd_i : dvd_i;
        dvs_mag_o  = dvs_neg_o ? -dvs_i : dvs_i;
        dvs_zero_o = (dvs_i == '0);
        mag_hi     = dvd_mag_o[DVD_W-1:DVS_W];
        // quotient magnitude would need more than DVS_W bits
        early_ovf_o = !dvs_zero_o && (mag_hi >= HI_W'(dvs_mag_o));
    end

endmodule

// File: rtl/div_restore_step.sv
`timescale 1ns/1ps
// One restoring step: shift the next dividend bit into the partial
// remainder, subtract the divisor when it fits, and shift the outcome
// into the freed LSB of the accumulator.
module div_restore_step #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic [DVS_W-1:0] rem_i,
    input  logic [DVD_W-1:0] acc_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic [DVS_W-1:0] rem_o,
    output logic [DVD_W-1:0] acc_o
);
    logic [DVS_W:0] trial;
    logic [DVS_W:0] diff;
    logic           fits;

    always_comb begin
        trial = {rem_i, acc_i[DVD_W-1]};
        diff  = trial - {1'b0, dvs_i};
        fits  = (trial >= {1'b0, dvs_i});
        rem_o = fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        acc_o = {acc_i[DVD_W-2:0], fits};
    end

endmodule

// File: rtl/div_result_fix.sv
`timescale 1ns/1ps
// Applies operand signs to the quotient and remainder magnitudes,
// detects overflow of the 16-bit quotient and derives N and Z.
module div_result_fix #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             sgn_i,
    input  logic             dvd_neg_i,
    input  logic             dvs_neg_i,
    input  logic [DVD_W-1:0] q_mag_i,
    input  logic [DVS_W-1:0] r_mag_i,
    output logic [DVD_W-1:0] result_o,
    output logic             ovf_o,
    output logic             neg_o,
    output logic             zero_o
);
    localparam int EXT_W = DVD_W - DVS_W + 1;

    logic [DVD_W-1:0] q_s;
    logic [DVS_W-1:0] r_s;
    logic [EXT_W-1:0] q_ext;

    always_comb begin
        q_s   = (sgn_i && (dvd_neg_i ^ dvs_neg_i)) ? -q_mag_i : q_mag_i;
        r_s   = (sgn_i && dvd_neg_i) ? -r_mag_i : r_mag_i;
        q_ext = q_s[DVD_W-1:DVS_W-1];
        if (sgn_i) begin
            ovf_o = !((&q_ext) || (q_ext == '0));
        end else begin
            ovf_o = |q_mag_i[DVD_W-1:DVS_W];
        end
        result_o = {r_s, q_s[DVS_W-1:0]};
        neg_o    = q_s[DVS_W-1];
        zero_o   = (q_s[DVS_W-1:0] == '0);
    end

endmodule

// File: rtl/seq_div32x16.sv
`timescale 1ns/1ps
module seq_div32x16
    import div_pkg::*;
#(
    parameter int          DVD_W       = 32,
    parameter int          DVS_W       = 16,
    parameter int          STEPS       = 1,
    parameter int          VEC_W       = 8,
    parameter logic [7:0]  TRAP_VECTOR = 8'h14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVD_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             wr_en_o,
    output logic [DVD_W-1:0] result_o,
    output logic [3:0]       flags_o,
    output logic             trap_o,
    output logic [VEC_W-1:0] trap_vec_o
);
    localparam int ITER  = DVD_W / STEPS;
    localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

    div_state_e state_q, state_d;

    logic [DVD_W-1:0] acc_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_mag_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sgn_q, dvd_neg_q, dvs_neg_q;

    logic             done_q, wr_en_q, trap_q;
    logic [DVD_W-1:0] result_q;
    div_ccr_t         ccr_q;

    // operand preparation
    logic [DVD_W-1:0] p_dvd_mag;
    logic [DVS_W-1:0] p_dvs_mag;
    logic             p_dvd_neg, p_dvs_neg, p_zero, p_early;

    div_operand_prep #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_prep (
        .sgn_i       (signed_i),
        .dvd_i       (dividend_i),
        .dvs_i       (divisor_i[DVS_W-1:0]),
        .dvd_mag_o   (p_dvd_mag),
        .dvs_mag_o   (p_dvs_mag),
        .dvd_neg_o   (p_dvd_neg),
        .dvs_neg_o   (p_dvs_neg),
        .dvs_zero_o  (p_zero),
        .early_ovf_o (p_early)
    );

    // chain of STEPS restoring steps per clock
    logic [DVS_W-1:0] rem_ch [STEPS+1];
    logic [DVD_W-1:0] acc_ch [STEPS+1];

    assign rem_ch[0] = rem_q;
    assign acc_ch[0] = acc_q;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        div_restore_step #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_step (
            .rem_i (rem_ch[g]),
            .acc_i (acc_ch[g]),
            .dvs_i (dvs_mag_q),
            .rem_o (rem_ch[g+1]),
            .acc_o (acc_ch[g+1])
        );
    end

    // sign fix-up and overflow
    logic [DVD_W-1:0] f_res;
    logic             f_ovf, f_neg, f_zero;

    div_result_fix #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_fix (
        .sgn_i     (sgn_q),
        .dvd_neg_i (dvd_neg_q),
        .dvs_neg_i (dvs_neg_q),
        .q_mag_i   (acc_q),
        .r_mag_i   (rem_q),
        .result_o  (f_res),
        .ovf_o     (f_ovf),
        .neg_o     (f_neg),
        .zero_o    (f_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                // START_LOOP; FINISH_FAST stays in idle
                if (start_i && !p_zero && !p_early) begin
                    state_d = S_RUN;
                end
            end
            S_RUN: begin
                // LOOP_DONE
                if (cnt_q == LAST) begin
                    state_d = S_FIX;
                end
            end
            S_FIX: begin
                // RETIRE
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            rem_q     <= '0;
            dvs_mag_q <= '0;
            cnt_q     <= '0;
            sgn_q     <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            done_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            trap_q    <= 1'b0;
            result_q  <= '0;
            ccr_q     <= '0;
        end else begin
            done_q  <= 1'b0;
            wr_en_q <= 1'b0;
            trap_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        acc_q     <= p_dvd_mag;
                        rem_q     <= '0;
                        dvs_mag_q <= p_dvs_mag;
                        cnt_q     <= '0;
                        sgn_q     <= signed_i;
                        dvd_neg_q <= p_dvd_neg;
                        dvs_neg_q <= p_dvs_neg;
                        if (p_zero) begin
                            done_q <= 1'b1;
                            trap_q <= 1'b1;
                        end else if (p_early) begin
                            done_q  <= 1'b1;
                            ccr_q.v <= 1'b1;
                            ccr_q.c <= 1'b0;
                        end
                    end
                end
                S_RUN: begin
                    acc_q <= acc_ch[STEPS];
                    rem_q <= rem_ch[STEPS];
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                S_FIX: begin
                    done_q <= 1'b1;
                    if (f_ovf) begin
                        ccr_q.v <= 1'b1;
                        ccr_q.c <= 1'b0;
                    end else begin
                        wr_en_q  <= 1'b1;
                        result_q <= f_res;
                        ccr_q    <= '{n: f_neg, z: f_zero, v: 1'b0, c: 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o     = (state_q != S_IDLE);
    assign done_o     = done_q;
    assign wr_en_o    = wr_en_q;
    assign trap_o     = trap_q;
    assign trap_vec_o = trap_q ? VEC_W'(TRAP_VECTOR) : '0;
    assign result_o   = result_q;
    assign flags_o    = ccr_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_o);

    // R1
    trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (done_q && !wr_en_q && trap_vec_o == VEC_W'(TRAP_VECTOR)));

    // R2
    divisor_hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && divisor_i[DVS_W-1:0] == '0
         && divisor_i[DVD_W-1:DVS_W] != '0) |=> trap_q);

    // R6
    ovf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ccr_q.v) |-> !wr_en_q);

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_q |-> $stable(result_q));

    // R5
    write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (!ccr_q.v && !ccr_q.c && ccr_q.n == result_q[DVS_W-1]
                     && ccr_q.z == (result_q[DVS_W-1:0] == '0)));

    // R3
    loop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && cnt_q != LAST) |=>
        (state_q == S_RUN && cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R10
    busy_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(sgn_q) && $stable(dvs_mag_q)));

endmodule

// File: tb/test_seq_div32x16.sv
`timescale 1ns/1ps
module test_seq_div32x16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0;
    logic [31:0] dvd = '0;
    logic [31:0] dvs = '0;
    logic        busy, done, wr_en, trap;
    logic [31:0] result;
    logic [3:0]  flags;
    logic [7:0]  trap_vec;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] m_res = '0;
    logic [3:0]  m_flags = '0;

    always #5 clk = ~clk;

    seq_div32x16 i_seq_div32x16 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .signed_i   (sgn),
        .dividend_i (dvd),
        .divisor_i  (dvs),
        .busy_o     (busy),
        .done_o     (done),
        .wr_en_o    (wr_en),
        .result_o   (result),
        .flags_o    (flags),
        .trap_o     (trap),
        .trap_vec_o (trap_vec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // generic run: drives one division, computes expectations, checks outputs
    task automatic run_div(input bit s, input logic [31:0] a, input logic [31:0] b,
                           input string req);
        logic [15:0] bl;
        longint aa, bb, q, r, ma, mb;
        bit is_trap, ovf, early, busy_ok;
        int exp_lat, n;
        bl = b[15:0];
        if (s) begin
            aa = longint'($signed(a));
            bb = longint'($signed(bl));
        end else begin
            aa = longint'({32'd0, a});
            bb = longint'({48'd0, bl});
        end
        is_trap = (bl == 16'd0);
        q = 0; r = 0; ovf = 0; early = 0;
        if (!is_trap) begin
            q = aa / bb;
            r = aa % bb;
            ovf = s ? (q > 32767 || q < -32768) : (q > 65535);
            ma = (aa < 0) ? -aa : aa;
            mb = (bb < 0) ? -bb : bb;
            early = ((ma >>> 16) >= mb);
        end
        exp_lat = (is_trap || early) ? 1 : 34;

        @(negedge clk);
        dvd = a; dvs = b; sgn = s; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 1;
        busy_ok = 1'b1;
        while (!done && n < 60) begin
            if (!busy) busy_ok = 1'b0;
            @(posedge clk); #1;
            n++;
        end
        chk(busy_ok, "R9", {req, " busy while looping"}, 0, 1);
        chk(n == exp_lat, (is_trap ? "R1" : (early ? "R7" : "R3")),
            {req, " latency"}, n, exp_lat);
        chk(trap == is_trap, "R1", {req, " trap"}, trap, is_trap);
        chk(trap_vec == (is_trap ? 8'h14 : 8'h00), "R1", {req, " vector"},
            trap_vec, is_trap ? 8'h14 : 8'h00);
        chk(wr_en == (!is_trap && !ovf), ovf ? "R6" : "R3", {req, " wr_en"},
            wr_en, !is_trap && !ovf);
        if (!is_trap) begin
            if (ovf) begin
                m_flags[1] = 1'b1;
                m_flags[0] = 1'b0;
            end else begin
                m_res   = {r[15:0], q[15:0]};
                m_flags = {q[15], (q[15:0] == 16'd0), 1'b0, 1'b0};
            end
        end
        chk(result == m_res, req, {req, " result"}, result, m_res);
        chk(flags == m_flags, "R5", {req, " flags"}, flags, m_flags);
        chk(!busy, "R9", {req, " busy low at done"}, busy, 0);
        @(posedge clk); #1;
        chk(!done && !wr_en && !trap, "R9", {req, " done pulse width"},
            {done, wr_en, trap}, 0);
    endtask

    // R11
    task automatic t_reset();
        #1;
        chk(!busy && !done && !wr_en && !trap, "R11", "control outputs in reset",
            {busy, done, wr_en, trap}, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(result == 0 && flags == 0 && !busy, "R11", "outputs after reset",
            {result, flags}, 0);
    endtask

    task automatic t_unsigned_basic();
        run_div(1'b0, 32'd100000, 32'd7, "R3");
    endtask

    task automatic t_zero_quotient();
        run_div(1'b0, 32'd5, 32'd9, "R5");
    endtask

    task automatic t_unsigned_bit15();
        run_div(1'b0, 32'h8000_0000, 32'h0000_FFFF, "R5");
    endtask

    // R6: Z from previous zero quotient must be kept; result held
    task automatic t_overflow_hold();
        run_div(1'b0, 32'd5, 32'd9, "R5");
        run_div(1'b0, 32'h0001_0000, 32'd1, "R6");
    endtask

    task automatic t_early();
        run_div(1'b0, 32'hFFFF_FFFF, 32'h0000_FFFF, "R7");
        run_div(1'b1, 32'hFFF0_0000, 32'd3, "R7");
    endtask

    task automatic t_signed_mix();
        run_div(1'b1, -32'sd7, 32'd2, "R4");
        run_div(1'b1, 32'd7, 32'h0000_FFFE, "R4");
        run_div(1'b1, -32'sd7, 32'h0000_FFFE, "R4");
        run_div(1'b1, 32'd1000, 32'd33, "R4");
    endtask

    task automatic t_signed_late_ovf();
        run_div(1'b1, 32'h0000_8000, 32'd1, "R8");
    endtask

    task automatic t_signed_min();
        run_div(1'b1, 32'hFFFF_8000, 32'd1, "R4");
    endtask

    task automatic t_divisor_upper();
        run_div(1'b0, 32'd100, 32'h0003_0005, "R2");
        run_div(1'b1, 32'd100, 32'h1234_FFFE, "R2");
    endtask

    task automatic t_trap();
        run_div(1'b0, 32'd1234, 32'h0007_0000, "R1");
        run_div(1'b1, 32'hFFFF_FFFF, 32'd0, "R1");
    endtask

    // R10: second start during the loop must not disturb the first division
    task automatic t_busy_ignore();
        int n;
        @(negedge clk);
        dvd = 32'd100000; dvs = 32'd7; sgn = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 1;
        while (!done && n < 60) begin
            if (n == 5) begin
                start = 1'b1; dvd = 32'd9; dvs = 32'd0; sgn = 1'b1;
            end
            if (n == 10) start = 1'b0;
            @(posedge clk); #1;
            n++;
        end
        chk(n == 34, "R10", "latency with start while busy", n, 34);
        chk(!trap, "R10", "no trap from ignored start", trap, 0);
        chk(result == {16'd5, 16'd14285}, "R10", "result of first op",
            result, {16'd5, 16'd14285});
        m_res = {16'd5, 16'd14285};
        m_flags = 4'b0000;
        repeat (5) @(posedge clk);
        #1;
        chk(!done && !busy, "R10", "no second operation", {done, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unsigned_basic();
        t_zero_quotient();
        t_unsigned_bit15();
        t_overflow_hold();
        t_early();
        t_signed_mix();
        t_signed_late_ovf();
        t_signed_min();
        t_divisor_upper();
        t_trap();
        t_busy_ignore();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule